// File: doc/BRIEF.md
# Exact Signed Integer to Register-Format Float Converter

This block takes a 64-bit two's-complement integer that sits in the significand field of a wide floating-point register value. It turns that integer into a normalized value with a sign bit, a 17-bit biased exponent and a 64-bit significand with an explicit leading one. A 64-bit significand holds every 64-bit integer magnitude, so the conversion is always exact. There is no rounding stage and no exception output. The source sign and exponent fields have no effect on the result, with one exception: a source whose fields match the reserved not-a-value token gives that same token at the output instead of a converted number.

Each request is a single-cycle valid strobe. It carries the source fields, a predicate bit that enables the write, and a flag that says the source or destination register is disabled. One clock later the block presents the result fields, a valid strobe and exactly one of two outcomes: a write-enable or a fault. The surrounding pipeline delivers the fault and writes the register. Normalization uses a leading-zero count and a left shift. A parameter selects one of two architectures for that step.

Top module: `sitf_convert`

## Requirements
- R1: A source significand with bit 63 clear gives sign 0. The significand is the integer shifted left until bit 63 is 1 (for example 5 gives significand 0xA000_0000_0000_0000 and exponent 0x10001).
- R2: A source significand with bit 63 set gives sign 1. The magnitude is the two's-complement negation of the integer (for example -1 gives significand 0x8000_0000_0000_0000 and exponent 0xFFFF).
- R3: For a nonzero integer, the result exponent is 0x1003E minus the number of leading zeros of the magnitude, and bit 63 of the result significand is 1.
- R4: A zero integer gives sign 0, exponent 0 and significand 0.
- R5: The integer -2^63 gives sign 1, exponent 0x1003E and significand 0x8000_0000_0000_0000.
- R6: A source with sign 0, exponent 0x1FFFE and significand 0 (the not-a-value token) gives sign 0, exponent 0x1FFFE and significand 0.
- R7: A request with the predicate bit at 0 raises neither write-enable nor fault.
- R8: A request with the predicate bit at 1 and the disabled flag at 1 raises fault and no write-enable. With the disabled flag at 0 it raises write-enable and no fault.
- R9: Output valid is input valid delayed by exactly one clock. Write-enable and fault are never high together and are high only while output valid is high.
- R10: The source sign and exponent fields have no effect on a converted result unless all three fields match the not-a-value token. A source with exponent 0x1FFFE and a nonzero significand is converted as an integer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_pred | input | 1 | Predicate; 1 enables the write |
| in_reg_disabled | input | 1 | Source or destination register disabled |
| src_sign | input | 1 | Source sign field |
| src_exp | input | 17 | Source exponent field |
| src_sig | input | 64 | Source significand, the integer operand |
| out_valid | output | 1 | Result strobe, one clock after the request |
| out_wr_en | output | 1 | Result must be written |
| out_fault | output | 1 | Disabled-register fault instead of a write |
| res_sign | output | 1 | Result sign |
| res_exp | output | 17 | Result biased exponent |
| res_sig | output | 64 | Result significand, explicit leading one |

## Verification
Two functions can land in the same output cycle: the not-a-value pass-through on the data fields and the disabled-register fault on the control outputs. The bench sends the token with the disabled flag set, with the predicate both on and off, and also sends it back to back with ordinary integers. For each cycle the scoreboard expects the token on the data fields together with a fault and no write, or with neither strobe. A test also places a nonzero significand under the token's exponent, which must be converted as a number.

// File: rtl/sitf_pkg.sv
package sitf_pkg;
   localparam int unsigned DEF_SIG_W   = 64;
   localparam int unsigned DEF_EXP_W   = 17;
   localparam int unsigned DEF_BIAS    = 32'h0000_FFFF;

   typedef enum logic [1:0] {
      KIND_NUM  = 2'd0,
      KIND_ZERO = 2'd1,
      KIND_NAT  = 2'd2
   } res_kind_e;

   localparam int unsigned ARCH_CASCADE = 0;
   localparam int unsigned ARCH_SCAN    = 1;
endpackage

// File: rtl/sitf_absval.sv
module sitf_absval #(
   parameter int unsigned W = 64
) (
   input  logic [W-1:0] val_i,
   output logic         neg_o,
   output logic [W-1:0] mag_o
);
   if (W < 2) begin : g_bad_w
      $error("sitf_absval: W must be at least 2");
   end

   logic [W-1:0] inv;

   always_comb begin
      neg_o = val_i[W-1];
      inv   = ~val_i;
      mag_o = neg_o ? (inv + {{(W-1){1'b0}}, 1'b1}) : val_i;
   end
endmodule

// File: rtl/sitf_normalize.sv
module sitf_normalize #(
   parameter int unsigned W    = 64,
   parameter int unsigned ARCH = sitf_pkg::ARCH_CASCADE,
   localparam int unsigned CNT_W = $clog2(W)
) (
   input  logic [W-1:0]     val_i,
   output logic [W-1:0]     sig_o,
   output logic [CNT_W-1:0] lz_o,
   output logic             zero_o
);
   if ((1 << CNT_W) != W || W < 2) begin : g_bad_w
      $error("sitf_normalize: W must be a power of two");
   end

   assign zero_o = (val_i == '0);

   if (ARCH == sitf_pkg::ARCH_CASCADE) begin : g_cascade
      logic [W-1:0] stg [CNT_W+1];
      assign stg[0] = val_i;
      for (genvar gi = 0; gi < CNT_W; gi++) begin : g_stage
         localparam int unsigned K  = CNT_W - 1 - gi;
         localparam int unsigned SH = 1 << K;
         logic empty;
         assign empty     = (stg[gi][W-1 -: SH] == '0);
         assign stg[gi+1] = empty ? (stg[gi] << SH) : stg[gi];
         assign lz_o[K]   = empty;
      end
      assign sig_o = stg[CNT_W];
   end else if (ARCH == sitf_pkg::ARCH_SCAN) begin : g_scan
      logic [CNT_W-1:0] cnt;
      logic             hit;
      always_comb begin
         cnt = '0;
         hit = 1'b0;
         for (int i = W - 1; i >= 0; i--) begin
            if (!hit) begin
               if (val_i[i]) hit = 1'b1;
               else          cnt = cnt + 1'b1;
            end
         end
      end
      assign lz_o  = cnt;
      assign sig_o = val_i << cnt;
   end else begin : g_bad_arch
      $error("sitf_normalize: unknown ARCH");
   end
endmodule

// File: rtl/sitf_convert.sv
module sitf_convert #(
   parameter int unsigned SIG_W     = sitf_pkg::DEF_SIG_W,
   parameter int unsigned EXP_W     = sitf_pkg::DEF_EXP_W,
   parameter int unsigned EXP_BIAS  = sitf_pkg::DEF_BIAS,
   parameter int unsigned NORM_ARCH = sitf_pkg::ARCH_CASCADE
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             in_pred,
   input  logic             in_reg_disabled,
   input  logic             src_sign,
   input  logic [EXP_W-1:0] src_exp,
   input  logic [SIG_W-1:0] src_sig,
   output logic             out_valid,
   output logic             out_wr_en,
   output logic             out_fault,
   output logic             res_sign,
   output logic [EXP_W-1:0] res_exp,
   output logic [SIG_W-1:0] res_sig
);
   import sitf_pkg::*;

   localparam int unsigned    CNT_W   = $clog2(SIG_W);
   localparam longint unsigned NAT_VAL = (64'd1 << EXP_W) - 64'd2;
   localparam logic [EXP_W-1:0] NAT_EXP = EXP_W'(NAT_VAL);
   localparam logic [EXP_W-1:0] INT_EXP = EXP_W'(EXP_BIAS + SIG_W - 1);

   if (EXP_W < 2 || EXP_W > 32) begin : g_bad_ew
      $error("sitf_convert: EXP_W out of range");
   end
   if (64'(EXP_BIAS) + 64'(SIG_W) - 64'd1 >= NAT_VAL) begin : g_bad_bias
      $error("sitf_convert: integer exponent collides with the token exponent");
   end
   if (64'(EXP_BIAS) < 64'(SIG_W)) begin : g_bad_small_bias
      $error("sitf_convert: bias too small for the normalization range");
   end

   // operand decode
   logic src_is_nat;
   assign src_is_nat = !src_sign && (src_exp == NAT_EXP) && (src_sig == '0);

   logic             neg;
   logic [SIG_W-1:0] mag;
   sitf_absval #(.W(SIG_W)) u_abs (
      .val_i (src_sig),
      .neg_o (neg),
      .mag_o (mag)
   );

   logic [SIG_W-1:0] nsig;
   logic [CNT_W-1:0] lz;
   logic             mag_zero;
   sitf_normalize #(.W(SIG_W), .ARCH(NORM_ARCH)) u_norm (
      .val_i  (mag),
      .sig_o  (nsig),
      .lz_o   (lz),
      .zero_o (mag_zero)
   );

   // result selection
   res_kind_e        kind;
   logic             nx_sign;
   logic [EXP_W-1:0] nx_exp;
   logic [SIG_W-1:0] nx_sig;

   always_comb begin
      if (src_is_nat)    kind = KIND_NAT;
      else if (mag_zero) kind = KIND_ZERO;
      else               kind = KIND_NUM;
      unique case (kind)
         KIND_NAT: begin
            nx_sign = 1'b0;
            nx_exp  = NAT_EXP;
            nx_sig  = '0;
         end
         KIND_ZERO: begin
            nx_sign = 1'b0;
            nx_exp  = '0;
            nx_sig  = '0;
         end
         default: begin
            nx_sign = neg;
            nx_exp  = INT_EXP - EXP_W'(lz);
            nx_sig  = nsig;
         end
      endcase
   end

   logic nx_wr, nx_fault;
   assign nx_wr    = in_valid && in_pred && !in_reg_disabled;
   assign nx_fault = in_valid && in_pred &&  in_reg_disabled;

   // output stage
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_wr_en <= 1'b0;
         out_fault <= 1'b0;
         res_sign  <= 1'b0;
         res_exp   <= '0;
         res_sig   <= '0;
      end else begin
         out_valid <= in_valid;
         out_wr_en <= nx_wr;
         out_fault <= nx_fault;
         if (in_valid) begin
            res_sign <= nx_sign;
            res_exp  <= nx_exp;
            res_sig  <= nx_sig;
         end
      end
   end

   // checks on the output stage
   assert_valid_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   assert_valid_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   assert_strobe_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(out_wr_en && out_fault));
   assert_strobe_in_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (out_wr_en || out_fault) |-> out_valid);
   assert_pred_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !in_pred) |=> (!out_wr_en && !out_fault));
   assert_fault_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_pred && in_reg_disabled) |=> (out_fault && !out_wr_en));
   assert_nat_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && src_is_nat) |=> (!res_sign && res_exp == NAT_EXP && res_sig == '0));
   assert_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && src_sig == '0 && !src_is_nat) |=> (!res_sign && res_exp == '0));
   assert_norm_msb_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && res_exp != '0 && res_exp != NAT_EXP) |-> res_sig[SIG_W-1]);
   assert_neg_sign_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !src_is_nat && src_sig[SIG_W-1]) |=> res_sign);
endmodule

// File: tb/sitf_convert_bench.sv
module sitf_convert_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, in_pred = 1'b0, in_reg_disabled = 1'b0;
   logic        src_sign = 1'b0;
   logic [16:0] src_exp = '0;
   logic [63:0] src_sig = '0;
   logic        out_valid, out_wr_en, out_fault, res_sign;
   logic [16:0] res_exp;
   logic [63:0] res_sig;

   always #2.5 clk = ~clk;

   sitf_convert u_sitf_convert (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_pred(in_pred),
      .in_reg_disabled(in_reg_disabled), .src_sign(src_sign), .src_exp(src_exp),
      .src_sig(src_sig), .out_valid(out_valid), .out_wr_en(out_wr_en),
      .out_fault(out_fault), .res_sign(res_sign), .res_exp(res_exp), .res_sig(res_sig)
   );

   typedef struct {
      int          cyc;
      logic        v, w, f, s;
      logic [16:0] e;
      logic [63:0] m;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int   n_tests = 0, n_fail = 0, cyc = 0;
   bit   mon_on = 1'b0, done = 1'b0;
   logic        last_s = 1'b0;
   logic [16:0] last_e = '0;
   logic [63:0] last_m = '0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic ref_conv(input logic sg, input logic [16:0] ex, input logic [63:0] sv,
                           output logic os, output logic [16:0] oe, output logic [63:0] om);
      logic [63:0] mg;
      int          nz;
      if (!sg && ex == 17'h1FFFE && sv == 64'd0) begin
         os = 1'b0; oe = 17'h1FFFE; om = 64'd0;
      end else begin
         os = sv[63];
         mg = sv[63] ? (64'd0 - sv) : sv;
         if (mg == 64'd0) begin
            os = 1'b0; oe = 17'd0; om = 64'd0;
         end else begin
            nz = 0;
            while (!mg[63]) begin
               mg = mg << 1;
               nz++;
            end
            oe = 17'h1003E - 17'(nz);
            om = mg;
         end
      end
   endtask

   task automatic drive(input logic v, input logic p, input logic d, input logic sg,
                        input logic [16:0] ex, input logic [63:0] sv, input string tag);
      exp_t it;
      @(negedge clk);
      in_valid = v; in_pred = p; in_reg_disabled = d;
      src_sign = sg; src_exp = ex; src_sig = sv;
      it.cyc = cyc; it.v = v; it.w = v && p && !d; it.f = v && p && d; it.tag = tag;
      if (v) begin
         ref_conv(sg, ex, sv, it.s, it.e, it.m);
         last_s = it.s; last_e = it.e; last_m = it.m;
      end else begin
         it.s = last_s; it.e = last_e; it.m = last_m;
      end
      exp_q.push_back(it);
      mon_on = 1'b1;
   endtask

   always @(negedge clk) begin
      if (mon_on && exp_q.size() > 0 && exp_q[0].cyc + 1 == cyc) begin
         exp_t it;
         it = exp_q.pop_front();
         n_tests++;
         if (out_valid !== it.v || out_wr_en !== it.w || out_fault !== it.f ||
             res_sign !== it.s || res_exp !== it.e || res_sig !== it.m) begin
            n_fail++;
            $display("FAIL %s: got v%b w%b f%b s%b e%h m%h, expected v%b w%b f%b s%b e%h m%h",
                     it.tag, out_valid, out_wr_en, out_fault, res_sign, res_exp, res_sig,
                     it.v, it.w, it.f, it.s, it.e, it.m);
         end
      end
   end

   function automatic logic [63:0] xs(input logic [63:0] x);
      logic [63:0] y;
      y = x ^ (x << 13);
      y = y ^ (y >> 7);
      y = y ^ (y << 17);
      return y;
   endfunction

   initial begin : main
      logic [63:0] r;
      repeat (3) @(negedge clk);
      n_tests++;
      if (out_valid !== 1'b0 || out_wr_en !== 1'b0 || out_fault !== 1'b0 ||
          res_exp !== 17'd0 || res_sig !== 64'd0) begin
         n_fail++;
         $display("FAIL R9 reset: got v%b w%b f%b e%h m%h, expected all zero",
                  out_valid, out_wr_en, out_fault, res_exp, res_sig);
      end
      rst_n = 1'b1;
      drive(1, 1, 0, 0, 17'd0, 64'd1, "R1 R3 one");
      drive(1, 1, 0, 0, 17'd0, 64'd5, "R1 five");
      drive(1, 1, 0, 0, 17'd0, 64'h7FFF_FFFF_FFFF_FFFF, "R1 R3 max positive");
      drive(1, 1, 0, 0, 17'd0, 64'hFFFF_FFFF_FFFF_FFFF, "R2 minus one");
      drive(1, 1, 0, 0, 17'd0, 64'hFFFF_FFFF_FFFF_FFFB, "R2 minus five");
      drive(0, 0, 0, 0, 17'd0, 64'd0, "R9 bubble");
      drive(1, 1, 0, 0, 17'd0, 64'd0, "R4 zero");
      drive(1, 1, 0, 0, 17'd0, 64'h8000_0000_0000_0000, "R5 most negative");
      drive(1, 1, 0, 0, 17'h1FFFE, 64'd0, "R6 token pass");
      drive(1, 0, 0, 0, 17'd0, 64'd77, "R7 predicate off");
      drive(1, 0, 1, 0, 17'h1FFFE, 64'd0, "R7 predicate off token disabled");
      drive(1, 1, 1, 0, 17'd0, 64'd9, "R8 fault");
      drive(1, 1, 1, 0, 17'h1FFFE, 64'd0, "R8 R6 fault with token");
      drive(1, 1, 0, 0, 17'd0, 64'h0000_0001_0000_0000, "R3 mid bit");
      drive(1, 1, 0, 1, 17'h01234, 64'd3, "R10 sign and exponent ignored");
      drive(1, 1, 0, 0, 17'h1FFFE, 64'd2, "R10 token exponent nonzero sig");
      drive(1, 1, 0, 1, 17'h1FFFE, 64'd0, "R10 token exponent with sign");
      drive(0, 1, 1, 0, 17'h1FFFE, 64'd0, "R9 idle with strobes set");
      r = 64'h1234_5678_9ABC_DEF1;
      for (int i = 0; i < 60; i++) begin
         r = xs(r);
         drive(r[0] | r[1], r[2] | r[3], r[4] & r[5], r[6], 17'(r[40:24]),
               r >> r[13:8], "R1 R2 R3 R8 random");
      end
      drive(0, 0, 0, 0, 17'd0, 64'd0, "R9 drain");
      drive(0, 0, 0, 0, 17'd0, 64'd0, "R9 drain");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL R9 watchdog: got hung run, expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule